// File: doc/BRIEF.md
# Flash Programming Control and Fault Register

This block is the control register that software uses to run in-application erase and program operations on on-chip flash. It sits on a simple 8-bit register bus. It holds four things: an enable bit for programming, a boot-source select bit, a bit that requests a software reset, and a sticky fault flag. Writes to the register are protected. A write is only accepted inside a short window that an unlock sequence opens.

When the flash controller raises a trigger, the block checks the requested command, its target address and the state of the supply. A legal command produces a one-cycle start pulse. An illegal command sets the fault flag instead, and no start pulse is produced. The programming enable bit also drives a request that keeps the timing oscillator running. The boot-select bit drives the reboot-source output. The bit keeps its value through a software reset, and every other reset loads it from a configuration pin.

Top module: `flash_prog_ctl`

## Requirements
- R1: After `rst_n` is asserted, the register reads `{6'b0, cfg_boot_sel, 1'b0}`. `osc_req`, `prog_start` and `swrst_req` are 0, and `boot_src` equals `cfg_boot_sel`.
- R2: At the control address, the read layout is: bit 0 programming enable, bit 1 boot select, bit 6 fault flag. Bits 7 and 5..2 always read 0.
- R3: A write to the control address takes effect only while the unlock window is open. The window opens when 0xAA and then 0x55 are written to the unlock address in two consecutive bus writes. It then stays open for the 4 clock cycles after the 0x55 write. Any other write in between cancels the sequence.
- R4: One accepted control write closes the window. A second write needs a new unlock.
- R5: `osc_req` equals the programming enable bit.
- R6: While the enable bit is 0, a trigger has no effect: no fault and no start pulse.
- R7: A trigger with an invalid `op_code` sets the fault flag. `op_code` = {3'b0, region, op[1:0]}, where region 0 is the application area and 1 is the loader area. op 00 is read, 01 is program and 10 is erase. op 11, or `op_code[3]`=1, is invalid.
- R8: A trigger whose `op_addr` is at or beyond the size of the selected region sets the fault flag.
- R9: A program or erase aimed at a region whose update-enable input is 0 sets the fault flag. A read is not affected.
- R10: A program or erase sets the fault flag when all four of these hold: `bod_low`=1, `bod_allow_n`=1, `bod_en`=1 and `bod_rst_en`=0.
- R11: Hardware never clears the fault flag. Only an accepted write with bit 6 = 0 clears it, or a software reset. Writing 1 to bit 6 has no effect.
- R12: An enabled trigger with no fault gives `prog_start` high for exactly one cycle, after one clock, and leaves the fault flag 0.
- R13: An accepted write with bit 7 = 1 gives `swrst_req` high for one cycle. Bit 7 reads as 0.
- R14: `sw_rst` clears the enable bit, the fault flag and the unlock state, and keeps boot select. `rst_n` loads boot select from `cfg_boot_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset (non-software reset), active low |
| sw_rst | input | 1 | Synchronous software reset that keeps boot select |
| cfg_boot_sel | input | 1 | Configuration value for boot select |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | BUS_AW | Bus address |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Register read data (0 off the control address) |
| trig | input | 1 | Operation trigger strobe |
| op_code | input | 4 | Requested command |
| op_addr | input | FA_W | Target byte address |
| app_upd_en | input | 1 | Application area update enabled |
| ldr_upd_en | input | 1 | Loader area update enabled |
| bod_low | input | 1 | Supply below the brown-out level |
| bod_en | input | 1 | Brown-out detection enabled |
| bod_rst_en | input | 1 | Brown-out reset enabled |
| bod_allow_n | input | 1 | Brown-out programming option, 1 = unprogrammed |
| osc_req | output | 1 | Keep-running request to the timing oscillator |
| boot_src | output | 1 | Reboot source: 0 application, 1 loader |
| prog_start | output | 1 | One-cycle start pulse to the flash controller |
| swrst_req | output | 1 | One-cycle software reset request |

## Verification
The assertions check on every cycle that the padding bits read zero and that the oscillator request follows the enable bit. They also check that the fault flag only falls after a clearing write or a software reset, that start pulses and reset requests only follow an enabled trigger or an accepted write, and that boot select holds across a software reset. Some behaviour only the bench scenarios can show: the exact length of the unlock window, which of the four illegal-command checks fires at its boundary value, that a write is rejected outside the window, and that boot select is reloaded from configuration.

// File: rtl/flash_prog_ctl.sv
module flash_prog_ctl #(
  parameter int BUS_AW      = 8,
  parameter int FA_W        = 16,
  parameter int APP_BYTES   = 49152,
  parameter int LDR_BYTES   = 4096,
  parameter int WIN_CYC     = 4,
  parameter logic [7:0] CTRL_ADDR   = 8'h10,
  parameter logic [7:0] UNLOCK_ADDR = 8'h11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_rst,
  input  logic              cfg_boot_sel,
  input  logic              bus_we,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              trig,
  input  logic [3:0]        op_code,
  input  logic [FA_W-1:0]   op_addr,
  input  logic              app_upd_en,
  input  logic              ldr_upd_en,
  input  logic              bod_low,
  input  logic              bod_en,
  input  logic              bod_rst_en,
  input  logic              bod_allow_n,
  output logic              osc_req,
  output logic              boot_src,
  output logic              prog_start,
  output logic              swrst_req
);
  localparam int CW = $clog2(WIN_CYC + 1);
  localparam logic [CW-1:0] WIN_LOAD = CW'(WIN_CYC);
  localparam logic [FA_W:0] APP_LIM = (FA_W+1)'(APP_BYTES);
  localparam logic [FA_W:0] LDR_LIM = (FA_W+1)'(LDR_BYTES);
  localparam logic [BUS_AW-1:0] A_CTRL = BUS_AW'(CTRL_ADDR);
  localparam logic [BUS_AW-1:0] A_UNL  = BUS_AW'(UNLOCK_ADDR);

  logic          en, bs, fault, seen_aa;
  logic [CW-1:0] win;

  wire ctrl_hit = bus_we && (bus_addr == A_CTRL);
  wire unl_hit  = bus_we && (bus_addr == A_UNL);
  wire win_open = (win != '0);
  wire wr_ok    = ctrl_hit && win_open;

  wire       rgn     = op_code[2];
  wire [1:0] op      = op_code[1:0];
  wire       is_mod  = (op == 2'b01) || (op == 2'b10);
  wire       invalid = op_code[3] || (op == 2'b11);
  wire       oversz  = {1'b0, op_addr} >= (rgn ? LDR_LIM : APP_LIM);
  wire       locked  = is_mod && !(rgn ? ldr_upd_en : app_upd_en);
  wire       bod_blk = is_mod && bod_low && bod_allow_n && bod_en && !bod_rst_en;
  wire       bad     = invalid || oversz || locked || bod_blk;
  wire       chk     = trig && en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en         <= 1'b0;
      bs         <= cfg_boot_sel;
      fault      <= 1'b0;
      seen_aa    <= 1'b0;
      win        <= '0;
      prog_start <= 1'b0;
      swrst_req  <= 1'b0;
    end else if (sw_rst) begin
      en         <= 1'b0;
      fault      <= 1'b0;
      seen_aa    <= 1'b0;
      win        <= '0;
      prog_start <= 1'b0;
      swrst_req  <= 1'b0;
    end else begin
      prog_start <= chk && !bad;
      swrst_req  <= wr_ok && bus_wdata[7];
      fault      <= (chk && bad) || (fault && !(wr_ok && !bus_wdata[6]));
      if (wr_ok) begin
        en <= bus_wdata[0];
        bs <= bus_wdata[1];
      end
      if (bus_we) seen_aa <= unl_hit && (bus_wdata == 8'hAA);
      if (wr_ok)
        win <= '0;
      else if (unl_hit && seen_aa && (bus_wdata == 8'h55))
        win <= WIN_LOAD;
      else if (win_open)
        win <= win - 1'b1;
    end
  end

  assign bus_rdata = (bus_addr == A_CTRL) ? {1'b0, fault, 4'b0000, bs, en} : 8'h00;
  assign osc_req   = en;
  assign boot_src  = bs;
endmodule

module flash_prog_ctl_chk #(
  parameter int BUS_AW = 8,
  parameter logic [7:0] CTRL_ADDR = 8'h10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sw_rst,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              trig,
  input logic              osc_req,
  input logic              boot_src,
  input logic              prog_start,
  input logic              swrst_req,
  input logic              wr_ok,
  input logic              fault
);
  localparam logic [BUS_AW-1:0] A_CTRL = BUS_AW'(CTRL_ADDR);

  a_r2_pad_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CTRL) |-> (bus_rdata[7] == 1'b0 && bus_rdata[5:2] == 4'b0000));

  a_r5_osc_follows_en: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_CTRL) |-> (osc_req == bus_rdata[0]));

  a_r11_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault) |-> ($past(wr_ok && !bus_wdata[6]) || $past(sw_rst)));

  a_r6_idle_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_req |=> !$rose(fault));

  a_r12_start_needs_trig: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> $past(trig && osc_req));

  a_r12_start_excl_fault: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> !$rose(fault));

  a_r13_swrst_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_req |-> $past(wr_ok && bus_wdata[7]));

  a_r14_bs_kept_on_swrst: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst |=> (boot_src == $past(boot_src)));
endmodule

bind flash_prog_ctl flash_prog_ctl_chk #(.BUS_AW(BUS_AW), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .trig(trig), .osc_req(osc_req), .boot_src(boot_src),
  .prog_start(prog_start), .swrst_req(swrst_req), .wr_ok(wr_ok), .fault(fault)
);

// File: tb/tb_flash_prog_ctl.sv
module tb_flash_prog_ctl;
  localparam logic [7:0] CTRL = 8'h10;
  localparam logic [7:0] UNL  = 8'h11;

  logic clk = 0, rst_n = 0, sw_rst = 0, cfg_boot_sel = 1;
  logic bus_we = 0;
  logic [7:0] bus_addr = CTRL, bus_wdata = 0, bus_rdata;
  logic trig = 0;
  logic [3:0] op_code = 0;
  logic [15:0] op_addr = 0;
  logic app_upd_en = 1, ldr_upd_en = 1, bod_low = 0, bod_en = 0, bod_rst_en = 0, bod_allow_n = 1;
  logic osc_req, boot_src, prog_start, swrst_req;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_prog_ctl dut (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .cfg_boot_sel(cfg_boot_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trig(trig), .op_code(op_code), .op_addr(op_addr), .app_upd_en(app_upd_en),
    .ldr_upd_en(ldr_upd_en), .bod_low(bod_low), .bod_en(bod_en), .bod_rst_en(bod_rst_en),
    .bod_allow_n(bod_allow_n), .osc_req(osc_req), .boot_src(boot_src),
    .prog_start(prog_start), .swrst_req(swrst_req)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0; bus_addr = CTRL;
  endtask

  task automatic unlock();
    wr(UNL, 8'hAA);
    wr(UNL, 8'h55);
  endtask

  task automatic pwr(logic [7:0] d);
    unlock();
    wr(CTRL, d);
  endtask

  task automatic trg(string req, logic [3:0] c, logic [15:0] a, logic exp_start, logic exp_fault);
    trig = 1; op_code = c; op_addr = a;
    @(negedge clk);
    trig = 0;
    #1;
    check({req, " start"}, {7'b0, prog_start}, {7'b0, exp_start});
    check({req, " fault"}, {7'b0, bus_rdata[6]}, {7'b0, exp_fault});
    @(negedge clk);
    check({req, " start drop"}, {7'b0, prog_start}, 8'h00);
    if (bus_rdata[6]) pwr(8'h01);
  endtask

  task automatic t_reset();
    #1;
    check("R1 reg", bus_rdata, 8'h02);
    check("R1 outs", {4'b0, osc_req, boot_src, prog_start, swrst_req}, 8'h04);
  endtask

  task automatic t_unlock();
    wr(CTRL, 8'h01); #1;
    check("R3 locked write", bus_rdata, 8'h02);
    unlock(); repeat (4) @(negedge clk);
    wr(CTRL, 8'h01); #1;
    check("R3 window expired", bus_rdata, 8'h02);
    wr(UNL, 8'hAA); wr(CTRL + 8'h1, 8'h00); wr(UNL, 8'h55);
    wr(CTRL, 8'h01); #1;
    check("R3 broken sequence", bus_rdata, 8'h02);
    unlock(); repeat (3) @(negedge clk);
    wr(CTRL, 8'h01); #1;
    check("R3 last window cycle", bus_rdata, 8'h01);
    check("R5 osc on", {7'b0, osc_req}, 8'h01);
    wr(CTRL, 8'h00); #1;
    check("R4 second write", bus_rdata, 8'h01);
  endtask

  task automatic t_layout();
    unlock();
    wr(CTRL, 8'hFF);
    check("R13 swrst pulse", {7'b0, swrst_req}, 8'h01);
    #1;
    check("R2 layout", bus_rdata, 8'h03);
    @(negedge clk);
    check("R13 swrst drop", {7'b0, swrst_req}, 8'h00);
    pwr(8'h01); #1;
    check("R5 osc follows", {7'b0, osc_req, bus_rdata[0]}, 8'h03);
  endtask

  task automatic t_ops();
    trg("R12 valid program", 4'h1, 16'h0100, 1, 0);
    trg("R7 invalid op", 4'h3, 16'h0000, 0, 1);
    trg("R7 high bit", 4'h9, 16'h0000, 0, 1);
    trg("R8 loader last byte", 4'h5, 16'd4095, 1, 0);
    trg("R8 loader oversize", 4'h5, 16'd4096, 0, 1);
    trg("R8 app oversize", 4'h0, 16'd49152, 0, 1);
    app_upd_en = 0;
    trg("R9 erase locked", 4'h2, 16'h0010, 0, 1);
    trg("R9 read unlocked", 4'h0, 16'h0010, 1, 0);
    app_upd_en = 1;
    bod_low = 1; bod_en = 1; bod_rst_en = 0; bod_allow_n = 1;
    trg("R10 bod block", 4'h1, 16'h0020, 0, 1);
    bod_allow_n = 0;
    trg("R10 option allows", 4'h1, 16'h0020, 1, 0);
    bod_allow_n = 1; bod_rst_en = 1;
    trg("R10 reset enabled", 4'h1, 16'h0020, 1, 0);
    bod_low = 0; bod_en = 0; bod_rst_en = 0;
  endtask

  task automatic t_fault_clear();
    trig = 1; op_code = 4'h3;
    @(negedge clk); trig = 0;
    repeat (3) @(negedge clk); #1;
    check("R11 held", bus_rdata, 8'h41);
    pwr(8'h41); #1;
    check("R11 write one", bus_rdata, 8'h41);
    pwr(8'h01); #1;
    check("R11 cleared", bus_rdata, 8'h01);
  endtask

  task automatic t_disabled();
    pwr(8'h00); #1;
    check("R6 disabled", bus_rdata, 8'h00);
    trig = 1; op_code = 4'h3;
    @(negedge clk); trig = 0; #1;
    check("R6 no start", {7'b0, prog_start}, 8'h00);
    check("R6 no fault", bus_rdata, 8'h00);
  endtask

  task automatic t_resets();
    pwr(8'h03); #1;
    check("R14 set", bus_rdata, 8'h03);
    sw_rst = 1; @(negedge clk); sw_rst = 0; #1;
    check("R14 sw reset keeps bs", bus_rdata, 8'h02);
    check("R14 boot_src", {7'b0, boot_src}, 8'h01);
    cfg_boot_sel = 0; rst_n = 0; @(negedge clk); rst_n = 1; #1;
    check("R14 por loads cfg", bus_rdata, 8'h00);
    check("R1 boot_src cfg", {7'b0, boot_src}, 8'h00);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_unlock();
    t_layout();
    t_ops();
    t_fault_clear();
    t_disabled();
    t_resets();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule